// File: doc/BRIEF.md
# Vector Mask Generate and Merge Unit

This block builds and applies a per-element mask for vector operations over up to 64 elements. An operation is started with a single pulse that also samples a 6-bit length, a mode and a test criterion. From then on one operand element is presented per clock, starting at element 0 and stepping through consecutive elements until the captured length is reached.

In generate mode each element of the first operand stream is tested against the selected criterion. The mask is cleared as the operation starts, and one bit is recorded per element. In merge mode two operand streams are presented together, and the mask bit of each element picks which stream supplies the result element. Outside an operation, a 64-bit scalar value can be written into the mask. The mask is always visible at an output, so a scalar register can read it back.

Top module: `vmask_unit`

## Requirements
- R1: The length input is 6 bits wide. A value n from 1 to 63 processes n elements, and the value 0 processes 64 elements.
- R2: The length, mode and criterion are sampled on the clock edge where a start is accepted. Changing the inputs later does not alter the operation in progress.
- R3: Element indices start at 0 and rise by one per clock. elem_idx_o shows the index of the element that the current cycle's operands must carry.
- R4: Element k maps to mask bit 63-k. Element 0 owns the most significant bit and element 63 owns bit 0.
- R5: A generate operation clears the whole mask on its start edge and then writes one bit per processed element. Bits of elements at or beyond the captured length read 0 afterwards.
- R6: The criterion codes are: 0 passes a zero element, 1 passes a nonzero element, 2 passes an element whose bit 63 is clear, and 3 passes an element whose bit 63 is set. A passing element records a 1.
- R7: During a merge, res_valid_o is high and res_o equals a_i when the element's mask bit is 1, or b_i when it is 0. res_valid_o stays low during a generate and while idle.
- R8: A mask write with mask_wr_i loads mask_wdata_i at the next edge when busy_o is low. A mask write while busy_o is high is ignored.
- R9: busy_o rises on the edge after an accepted start and stays high for exactly as many cycles as the captured length. A start while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (accepted when idle) |
| mode_i | input | 1 | 0 = generate, 1 = merge |
| crit_i | input | 2 | Generate criterion code |
| vl_i | input | 6 | Vector length, 0 means 64 |
| a_i | input | 64 | First operand element stream |
| b_i | input | 64 | Second operand element stream |
| mask_wr_i | input | 1 | Load the mask from a scalar value |
| mask_wdata_i | input | 64 | Scalar value for the mask load |
| mask_o | output | 64 | Current mask contents |
| res_o | output | 64 | Merged result element |
| res_valid_o | output | 1 | res_o carries a merge element |
| busy_o | output | 1 | An operation is in progress |
| elem_idx_o | output | 6 | Index of the element expected this cycle |

## Verification
Generate runs use element streams that cycle through zero, small positive, sign-set and seed-derived words. Each of the four criteria therefore meets both passing and failing elements, and a criterion decoded wrongly, a swapped sign test or a reversed bit order gives a different mask. The lengths include 1, small values, 63 and the zero code. A count that is off by one, or the zero code decoded as zero elements, shows up as a wrong busy count and stray or missing high-order mask bits. Merge runs use a mask loaded from a scalar, with a and b streams that always differ, so selecting the wrong stream or the wrong bit is visible on every element. During runs, the length is changed, stray starts are issued and mask writes are attempted, to show that in-flight state is immune to them.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
  typedef enum logic {
    OP_GEN   = 1'b0,
    OP_MERGE = 1'b1
  } op_e;

  typedef enum logic [1:0] {
    CRIT_ZERO    = 2'd0,
    CRIT_NONZERO = 2'd1,
    CRIT_POS     = 2'd2,
    CRIT_NEG     = 2'd3
  } crit_e;
endpackage

// File: rtl/vmask_seq.sv
module vmask_seq #(
  parameter int ELEMS = 64,
  localparam int LEN_W = $clog2(ELEMS),
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] vl_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic [LEN_W-1:0] idx_o
);
  logic [CNT_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] idx_q;
  logic             busy_q, last;

  // zero length code stands for a full vector
  assign len_d    = (vl_i == '0) ? CNT_W'(ELEMS) : {1'b0, vl_i};
  assign accept_o = start_i & ~busy_q;
  assign last     = ({1'b0, idx_q} == (len_q - CNT_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (accept_o) begin
      len_q  <= len_d;
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + LEN_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/vmask_test.sv
module vmask_test
  import vmask_pkg::*;
#(
  parameter int WORD = 64
) (
  input  crit_e           crit_i,
  input  logic [WORD-1:0] data_i,
  output logic            pass_o
);
  logic is_zero, is_neg;
  assign is_zero = (data_i == '0);
  assign is_neg  = data_i[WORD-1];

  always_comb begin
    unique case (crit_i)
      CRIT_ZERO:    pass_o = is_zero;
      CRIT_NONZERO: pass_o = ~is_zero;
      CRIT_POS:     pass_o = ~is_neg;
      default:      pass_o = is_neg;
    endcase
  end
endmodule

// File: rtl/vmask_reg.sv
module vmask_reg #(
  parameter int ELEMS = 64,
  localparam int LEN_W = $clog2(ELEMS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [ELEMS-1:0] wr_data_i,
  input  logic             set_i,
  input  logic [LEN_W-1:0] set_idx_i,
  input  logic             set_val_i,
  input  logic [LEN_W-1:0] sel_idx_i,
  output logic             sel_o,
  output logic [ELEMS-1:0] mask_o
);
  logic [ELEMS-1:0] m_q;

  // bit i holds element ELEMS-1-i
  for (genvar i = 0; i < ELEMS; i++) begin : g_bit
    localparam int ELEM = ELEMS - 1 - i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      m_q[i] <= 1'b0;
      else if (clr_i)                                   m_q[i] <= 1'b0;
      else if (wr_i)                                    m_q[i] <= wr_data_i[i];
      else if (set_i && (set_idx_i == LEN_W'(ELEM)))    m_q[i] <= set_val_i;
    end
  end

  assign sel_o  = m_q[LEN_W'(ELEMS - 1) - sel_idx_i];
  assign mask_o = m_q;
endmodule

// File: rtl/vmask_unit.sv
module vmask_unit
  import vmask_pkg::*;
#(
  parameter int ELEMS = 64,
  parameter int WORD  = 64,
  localparam int LEN_W = $clog2(ELEMS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [1:0]       crit_i,
  input  logic [LEN_W-1:0] vl_i,
  input  logic [WORD-1:0]  a_i,
  input  logic [WORD-1:0]  b_i,
  input  logic             mask_wr_i,
  input  logic [ELEMS-1:0] mask_wdata_i,
  output logic [ELEMS-1:0] mask_o,
  output logic [WORD-1:0]  res_o,
  output logic             res_valid_o,
  output logic             busy_o,
  output logic [LEN_W-1:0] elem_idx_o
);
  op_e              mode_q;
  crit_e            crit_q;
  logic             accept, busy, pass, sel;
  logic [LEN_W-1:0] idx;

  vmask_seq #(.ELEMS(ELEMS)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .vl_i     (vl_i),
    .accept_o (accept),
    .busy_o   (busy),
    .idx_o    (idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= OP_GEN;
      crit_q <= CRIT_ZERO;
    end else if (accept) begin
      mode_q <= op_e'(mode_i);
      crit_q <= crit_e'(crit_i);
    end
  end

  vmask_test #(.WORD(WORD)) u_test (
    .crit_i (crit_q),
    .data_i (a_i),
    .pass_o (pass)
  );

  vmask_reg #(.ELEMS(ELEMS)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept && (op_e'(mode_i) == OP_GEN)),
    .wr_i      (mask_wr_i && !busy),
    .wr_data_i (mask_wdata_i),
    .set_i     (busy && (mode_q == OP_GEN)),
    .set_idx_i (idx),
    .set_val_i (pass),
    .sel_idx_i (idx),
    .sel_o     (sel),
    .mask_o    (mask_o)
  );

  assign res_valid_o = busy && (mode_q == OP_MERGE);
  assign res_o       = sel ? a_i : b_i;
  assign busy_o      = busy;
  assign elem_idx_o  = idx;
endmodule

// File: rtl/vmask_unit_chk.sv
module vmask_unit_chk #(
  parameter int ELEMS = 64,
  parameter int WORD  = 64,
  localparam int LEN_W = $clog2(ELEMS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             mode_i,
  input logic             mask_wr_i,
  input logic [ELEMS-1:0] mask_o,
  input logic [WORD-1:0]  a_i,
  input logic [WORD-1:0]  b_i,
  input logic [WORD-1:0]  res_o,
  input logic             res_valid_o,
  input logic             busy_o,
  input logic [LEN_W-1:0] elem_idx_o
);
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R9

  AST_START_IDX0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (elem_idx_o == '0)); // R3

  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (elem_idx_o == LEN_W'($past(elem_idx_o) + 1'b1))); // R3

  AST_GEN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !mode_i) |=> (mask_o == '0)); // R5

  AST_IDLE_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i && !mask_wr_i) |=> $stable(mask_o)); // R8

  AST_VALID_IN_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> busy_o); // R7

  AST_MERGE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> ((res_o == a_i) || (res_o == b_i))); // R7
endmodule

bind vmask_unit vmask_unit_chk #(.ELEMS(ELEMS), .WORD(WORD)) u_chk (.*);

// File: tb/vmask_unit_tb_top.sv
`timescale 1ns/1ps
module vmask_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [1:0]  crit_i = '0;
  logic [5:0]  vl_i = '0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic        mask_wr_i = 1'b0;
  logic [63:0] mask_wdata_i = '0;
  logic [63:0] mask_o, res_o;
  logic        res_valid_o, busy_o;
  logic [5:0]  elem_idx_o;

  int total = 0;
  int bad = 0;
  int seq_bad, merge_bad, busy_cnt;
  logic [63:0] mask_ref;

  always #10 clk_i = ~clk_i;

  vmask_unit dut_i (.*);

  typedef struct packed {
    logic [1:0] crit;
    logic [5:0] vl;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{crit: 2'd0, vl: 6'd4,  seed: 8'h00},
    '{crit: 2'd1, vl: 6'd8,  seed: 8'h13},
    '{crit: 2'd2, vl: 6'd0,  seed: 8'h21},
    '{crit: 2'd3, vl: 6'd63, seed: 8'h02},
    '{crit: 2'd0, vl: 6'd1,  seed: 8'h00},
    '{crit: 2'd2, vl: 6'd5,  seed: 8'h7f},
    '{crit: 2'd3, vl: 6'd0,  seed: 8'h01},
    '{crit: 2'd1, vl: 6'd33, seed: 8'h00}
  };

  function automatic logic [63:0] elem_val(input logic [7:0] seed, input int k);
    case ((k + int'(seed)) % 4)
      0:       return 64'h0;
      1:       return 64'(k + 1) << 8;
      2:       return {1'b1, 63'(k)};
      default: return {8'h00, 56'(seed)} ^ 64'(k & 2);
    endcase
  endfunction

  function automatic bit passes(input logic [1:0] crit, input logic [63:0] v);
    case (crit)
      2'd0:    return v == 64'h0;
      2'd1:    return v != 64'h0;
      2'd2:    return !v[63];
      default: return v[63];
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // runs one operation; a stray start, a length change and a mask write hit it mid-flight
  task automatic run_op(input logic mode, input logic [1:0] crit, input logic [5:0] vl,
                        input logic [7:0] seed);
    int len;
    len = (vl == 6'd0) ? 64 : int'(vl);
    seq_bad = 0; merge_bad = 0; busy_cnt = 0;
    @(negedge clk_i);
    start_i = 1'b1; mode_i = mode; crit_i = crit; vl_i = vl;
    @(negedge clk_i);
    start_i = 1'b0; vl_i = ~vl; crit_i = ~crit; mode_i = ~mode; // R2
    for (int k = 0; k < len; k++) begin
      a_i = elem_val(seed, k);
      b_i = ~a_i;
      mask_wr_i = (k == 1);
      mask_wdata_i = 64'hA5A5_0F0F_3C3C_FFFF;
      start_i = (k == 2);
      #2;
      if (busy_o) busy_cnt++;
      if (elem_idx_o != 6'(k)) seq_bad++;
      if (mode) begin
        if (!res_valid_o || res_o != (mask_ref[63-k] ? a_i : b_i)) merge_bad++;
      end else if (res_valid_o) merge_bad++;
      @(negedge clk_i);
      mask_wr_i = 1'b0; start_i = 1'b0;
    end
    #2;
    if (busy_o) busy_cnt++;
  endtask

  task automatic write_mask(input logic [63:0] v);
    @(negedge clk_i);
    mask_wr_i = 1'b1; mask_wdata_i = v;
    @(negedge clk_i);
    mask_wr_i = 1'b0;
    #2;
    chk(mask_o == v, "R8 idle mask write", mask_o, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 64'h0, 64'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(mask_o == 64'h0 && !busy_o && !res_valid_o && elem_idx_o == 6'd0,
        "R9 reset state", {mask_o[61:0], busy_o, res_valid_o}, 64'h0);
    rst_ni = 1'b1;

    // generate table
    foreach (VECS[i]) begin
      logic [63:0] exp;
      int len;
      len = (VECS[i].vl == 6'd0) ? 64 : int'(VECS[i].vl);
      exp = '0;
      for (int k = 0; k < len; k++)
        if (passes(VECS[i].crit, elem_val(VECS[i].seed, k))) exp[63-k] = 1'b1;
      write_mask(64'hFFFF_FFFF_FFFF_FFFF); // stale ones must be cleared (R5)
      run_op(1'b0, VECS[i].crit, VECS[i].vl, VECS[i].seed);
      chk(mask_o == exp, "R4 R5 R6 generate mask", mask_o, exp);
      chk(busy_cnt == len, "R1 R2 R9 busy length", 64'(busy_cnt), 64'(len));
      chk(seq_bad == 0, "R3 element index", 64'(seq_bad), 64'h0);
      chk(merge_bad == 0, "R7 no valid in generate", 64'(merge_bad), 64'h0);
    end

    // merge with mask from scalar
    mask_ref = 64'hC3A5_0000_FFFF_1248;
    write_mask(mask_ref);
    run_op(1'b1, 2'd0, 6'd0, 8'h11);
    chk(merge_bad == 0, "R7 merge select full", 64'(merge_bad), 64'h0);
    chk(busy_cnt == 64, "R1 zero code length", 64'(busy_cnt), 64'd64);
    chk(mask_o == mask_ref, "R8 write ignored while busy", mask_o, mask_ref);

    mask_ref = 64'h8000_0000_0000_0001;
    write_mask(mask_ref);
    run_op(1'b1, 2'd3, 6'd3, 8'h05);
    chk(merge_bad == 0, "R7 merge select short", 64'(merge_bad), 64'h0);
    chk(busy_cnt == 3, "R9 stray start ignored", 64'(busy_cnt), 64'd3);
    chk(seq_bad == 0, "R3 merge index", 64'(seq_bad), 64'h0);

    // idle: no activity keeps mask, res_valid low
    repeat (3) @(negedge clk_i);
    #2;
    chk(mask_o == mask_ref && !res_valid_o && !busy_o, "R7 R8 idle hold", mask_o, mask_ref);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule